// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one short, arbitrary transaction on a single-bit SPI bus toward a serial flash device. Software loads up to six outgoing bytes into a bank of byte registers, writes the total number of bits to shift, and then writes the start code to the control register. The engine lowers chip select, clocks the whole bit string out MSB first in SPI mode 0, and shifts every incoming bit into a receive chain. The busy bit in the control register clears by itself once chip select rises again.

One count sets a single unified shift that covers the opcode, the transmit bytes and the receive bytes, for a total of `8 * (1 + txLen + rxLen)`. The outgoing bank is a 48-bit string. The byte at index 5 leaves first and usually holds the opcode. Any bits shifted after the bank is used up are zero. The receive chain holds up to seven bytes. Its newest byte sits at index 0, so the first byte received sits at index `rxLen - 1`.

SCK is derived from the system clock, and each SCK half period lasts `HALF_DIV` system cycles. Commands are refused until software has written the unlock code to the guard register.

Top module: `nor_cmd_shifter`

## Requirements
- R1: After reset, spiCsN is 1, spiSck is 0, and the control register (address 0x00) reads 0.
- R2: When the block is unlocked and idle, a write with bit 2 set to the control register (value 0x04) starts a transaction. While the transaction runs, the control register reads 0x04. It reads 0x00 again from the cycle in which spiCsN returns to 1.
- R3: A start is honoured only if the last value written to the guard register (address 0x02) was 0x30. Before that, or after any other value, a start write leaves spiCsN at 1 and produces no SCK edge.
- R4: spiMosi presents the outgoing bank MSB first. It starts with the byte at index 5 (address 0x0D) and goes down to index 0 (address 0x08). Every bit after the 48th is 0.
- R5: A transaction produces exactly as many SCK rising edges as the count register (address 0x01) holds. A count write above 56 is stored as 56.
- R6: The receive chain shifts each sampled spiMiso bit into bit 0, and older bits move upward. Receive byte i reads at address 0x10+i (i = 0..6). After n bits, byte i holds chain bits 8i+7..8i, so the last byte received is at index 0.
- R7: SPI mode 0 applies. spiSck is 0 whenever spiCsN is 1. spiMosi changes only while spiSck is 0. spiMiso is sampled on the rising edge.
- R8: The first SCK rising edge comes 3*HALF_DIV system cycles after spiCsN falls. spiCsN rises 2*HALF_DIV cycles after the last SCK falling edge.
- R9: While busy, writes to the outgoing byte registers, the count register and the control register are ignored.
- R10: The receive registers are cleared when a transaction starts. They keep their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address for write and read |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational on addr) |
| spiSck | output | 1 | SPI clock, idle low |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
Two events can fall in the same cycle. On the clock edge where SCK rises, a receive bit is captured. On the edge where SCK falls, the next outgoing bit shifts while the bit counter moves toward its final value. The bench checks each such rise against a queue of expected spiMosi bits filled by the driver. It then reads the receive bytes back, to judge whether capture and shifting stay aligned through the last bit, including the 56-bit case in which zeros follow the bank. A second overlap is a register write that arrives while a shift is in progress. The bench issues count, outgoing-byte and start writes in the middle of a transaction, and then confirms through read-back and the SCK edge count that none of them took effect.

// File: rtl/nor_shift_pkg.sv
package nor_shift_pkg;

  typedef struct packed {
    logic load;    // capture bank into shifter, clear receive chain
    logic sample;  // take spiMiso into receive chain (SCK rising)
    logic shift;   // advance outgoing shifter (SCK falling)
  } shStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD
  } shState_t;

  localparam logic [4:0] ADDR_CTRL    = 5'h00;
  localparam logic [4:0] ADDR_COUNT   = 5'h01;
  localparam logic [4:0] ADDR_GUARD   = 5'h02;
  localparam logic [4:0] ADDR_TX_BASE = 5'h08;
  localparam logic [4:0] ADDR_RX_BASE = 5'h10;

  localparam int        START_BIT   = 2;
  localparam logic [7:0] UNLOCK_CODE = 8'h30;

endpackage

// File: rtl/nor_shift_dp.sv
module nor_shift_dp
  import nor_shift_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 7,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [4:0]       addr,
  input  logic [7:0]       wrData,
  input  logic             busy,
  input  shStrobe_t        stb,
  input  logic             miso,
  output logic [7:0]       rdData,
  output logic [CNT_W-1:0] countVal,
  output logic             mosiBit,
  output logic             unlocked
);
  localparam int TX_BITS  = TX_BYTES * 8;
  localparam int RX_BITS  = RX_BYTES * 8;
  localparam int MAX_BITS = RX_BITS;

  logic [7:0]         txBank [TX_BYTES];
  logic [TX_BITS-1:0] txFlat;
  logic [TX_BITS-1:0] txShift;
  logic [RX_BITS-1:0] rxChain;
  logic [CNT_W-1:0]   countReg;
  logic               unlockReg;

  always_comb begin
    for (int i = 0; i < TX_BYTES; i++) txFlat[8*i +: 8] = txBank[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TX_BYTES; i++) txBank[i] <= '0;
      countReg  <= '0;
      unlockReg <= 1'b0;
      txShift   <= '0;
      rxChain   <= '0;
    end else begin
      if (wrEn && addr == ADDR_GUARD) unlockReg <= (wrData == UNLOCK_CODE);
      if (wrEn && !busy) begin
        if (addr == ADDR_COUNT) begin
          if (32'(wrData) > MAX_BITS) countReg <= CNT_W'(MAX_BITS);
          else                        countReg <= CNT_W'(wrData);
        end
        for (int i = 0; i < TX_BYTES; i++)
          if (addr == ADDR_TX_BASE + 5'(i)) txBank[i] <= wrData;
      end
      if (stb.load) begin
        txShift <= txFlat;
        rxChain <= '0;
      end else begin
        if (stb.shift)  txShift <= {txShift[TX_BITS-2:0], 1'b0};
        if (stb.sample) rxChain <= {rxChain[RX_BITS-2:0], miso};
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_CTRL)  rdData[START_BIT] = busy;
    if (addr == ADDR_COUNT) rdData = 8'(countReg);
    for (int i = 0; i < TX_BYTES; i++)
      if (addr == ADDR_TX_BASE + 5'(i)) rdData = txBank[i];
    for (int i = 0; i < RX_BYTES; i++)
      if (addr == ADDR_RX_BASE + 5'(i)) rdData = rxChain[8*i +: 8];
  end

  assign countVal = countReg;
  assign mosiBit  = txShift[TX_BITS-1];
  assign unlocked = unlockReg;

endmodule

// File: rtl/nor_shift_ctl.sv
module nor_shift_ctl
  import nor_shift_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] countVal,
  output shStrobe_t        stb,
  output logic             busy,
  output logic             sck,
  output logic             csN
);
  localparam int PW = $clog2(2 * HALF_DIV) < 1 ? 1 : $clog2(2 * HALF_DIV);
  localparam logic [PW-1:0] HALF_END = PW'(HALF_DIV - 1);
  localparam logic [PW-1:0] FULL_END = PW'(2 * HALF_DIV - 1);

  shState_t         state;
  logic [PW-1:0]    phase;
  logic [CNT_W-1:0] bitsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitsLeft <= '0;
    end else begin
      phase <= phase + 1'b1;
      unique case (state)
        ST_IDLE: begin
          phase <= '0;
          if (startReq) begin
            state    <= ST_SETUP;
            bitsLeft <= countVal;
          end
        end
        ST_SETUP: if (phase == FULL_END) begin
          phase <= '0;
          state <= (bitsLeft == '0) ? ST_HOLD : ST_LOW;
        end
        ST_LOW: if (phase == HALF_END) begin
          phase <= '0;
          state <= ST_HIGH;
        end
        ST_HIGH: if (phase == HALF_END) begin
          phase    <= '0;
          bitsLeft <= bitsLeft - 1'b1;
          state    <= (bitsLeft == CNT_W'(1)) ? ST_HOLD : ST_LOW;
        end
        ST_HOLD: if (phase == FULL_END) begin
          phase <= '0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load   = (state == ST_IDLE) && startReq;
    stb.sample = (state == ST_LOW) && (phase == HALF_END);
    stb.shift  = (state == ST_HIGH) && (phase == HALF_END) && (bitsLeft != CNT_W'(1));
  end

  assign sck  = (state == ST_HIGH);
  assign csN  = (state == ST_IDLE);
  assign busy = !csN;

endmodule

// File: rtl/nor_cmd_shifter.sv
module nor_cmd_shifter
  import nor_shift_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [4:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);
  localparam int MAX_BITS = RX_BYTES * 8;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  shStrobe_t        stb;
  logic             busy;
  logic             unlocked;
  logic             mosiBit;
  logic             startReq;
  logic [CNT_W-1:0] countVal;

  assign startReq = wrEn && (addr == ADDR_CTRL) && wrData[START_BIT] && unlocked && !busy;

  nor_shift_ctl #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .countVal(countVal),
    .stb(stb), .busy(busy), .sck(spiSck), .csN(spiCsN)
  );

  nor_shift_dp #(.TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busy(busy), .stb(stb), .miso(spiMiso), .rdData(rdData),
    .countVal(countVal), .mosiBit(mosiBit), .unlocked(unlocked)
  );

  assign spiMosi = busy ? mosiBit : 1'b0;

endmodule

// File: rtl/nor_cmd_shifter_chk.sv
module nor_cmd_shifter_chk #(
  parameter int CNT_W    = 6,
  parameter int MAX_BITS = 56
) (
  input logic             clk,
  input logic             rstN,
  input logic             spiSck,
  input logic             spiCsN,
  input logic             spiMosi,
  input logic             unlocked,
  input logic [CNT_W-1:0] countVal
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck); // R7

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi)); // R7

  AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> $past(unlocked)); // R3

  AST_COUNT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && !$past(spiCsN)) |-> $stable(countVal)); // R9

  AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    countVal <= CNT_W'(MAX_BITS)); // R5
endmodule

bind nor_cmd_shifter nor_cmd_shifter_chk #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) uChk (
  .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
  .unlocked(unlocked), .countVal(countVal)
);

// File: tb/nor_cmd_shifter_test.sv
module nor_cmd_shifter_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic spiSck, spiCsN, spiMosi, spiMiso;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int riseCount = 0;
  int csFallCyc = 0;
  int lastFallCyc = 0;
  int leadCyc = 0;
  int tailCyc = 0;
  logic firstRise = 1'b0;
  logic prevSck = 1'b0;
  logic prevCs = 1'b1;
  logic [63:0] slaveWord = '0;
  bit expQ[$];

  nor_cmd_shifter #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave drives bit k of its word before SCK rise k
  assign spiMiso = (riseCount < 64) ? slaveWord[63 - riseCount] : 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: scoreboard of MOSI bits plus edge timing
  always @(negedge clk) begin
    cyc++;
    if (!spiCsN && prevCs) begin
      csFallCyc = cyc;
      firstRise = 1'b1;
      riseCount = 0;
    end
    if (spiSck && !prevSck) begin
      if (firstRise) begin
        leadCyc = cyc - csFallCyc;
        firstRise = 1'b0;
      end
      if (expQ.size() == 0) chk("R5 extra SCK edge", 1, 0);
      else chk("R4 mosi bit", int'(spiMosi), int'(expQ.pop_front()));
      riseCount++;
    end
    if (!spiSck && prevSck) lastFallCyc = cyc;
    if (spiCsN && !prevCs) tailCyc = cyc - lastFallCyc;
    prevSck = spiSck;
    prevCs = spiCsN;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      chk("watchdog", 1, 0);
      finishRun();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  // driver: load bank, push expected bits, run, judge read-back
  task automatic runTxn(input logic [47:0] bank, input int cntWrite, input int nBits,
                        input logic [63:0] slv);
    logic [7:0] v;
    logic [55:0] expRx;
    for (int i = 0; i < 6; i++) wr(5'h08 + 5'(i), bank[8*i +: 8]);
    wr(5'h01, 8'(cntWrite));
    rd(5'h01, v);
    chk("R5 count readback", int'(v), nBits);
    slaveWord = slv;
    for (int b = 0; b < nBits; b++) expQ.push_back(b < 48 ? bank[47 - b] : 1'b0);
    wr(5'h00, 8'h04);
    rd(5'h10, v);
    chk("R10 rx cleared at start", int'(v), 0);
    rd(5'h00, v);
    chk("R2 busy reads 0x04", int'(v), 4);
    wr(5'h01, 8'd8);          // ignored while busy
    wr(5'h0D, 8'hEE);         // ignored while busy
    wr(5'h00, 8'h04);         // ignored while busy
    do @(negedge clk); while (!spiCsN);
    @(negedge clk);
    rd(5'h00, v);
    chk("R2 busy self-clears", int'(v), 0);
    chk("R5 rising edge count", riseCount, nBits);
    chk("R4 scoreboard drained", expQ.size(), 0);
    chk("R8 cs lead cycles", leadCyc, 3 * HALF);
    chk("R8 cs tail cycles", tailCyc, 2 * HALF);
    rd(5'h01, v);
    chk("R9 count unchanged", int'(v), nBits);
    rd(5'h0D, v);
    chk("R9 tx byte unchanged", int'(v), int'(bank[47:40]));
    expRx = 56'(slv >> (64 - nBits));
    for (int i = 0; i < 7; i++) begin
      rd(5'h10 + 5'(i), v);
      chk($sformatf("R6 rx byte %0d", i), int'(v), int'(expRx[8*i +: 8]));
    end
    repeat (5) @(negedge clk);
    rd(5'h10, v);
    chk("R10 rx held after done", int'(v), int'(expRx[7:0]));
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 csN after reset", int'(spiCsN), 1);
    chk("R1 sck after reset", int'(spiSck), 0);
    rd(5'h00, v);
    chk("R1 ctrl after reset", int'(v), 0);
    rstN = 1'b1;
    @(negedge clk);

    // locked: start ignored
    wr(5'h01, 8'd8);
    wr(5'h00, 8'h04);
    repeat (20) @(negedge clk);
    chk("R3 locked csN", int'(spiCsN), 1);
    chk("R3 locked no sck", riseCount, 0);
    wr(5'h02, 8'h31);
    wr(5'h00, 8'h04);
    repeat (20) @(negedge clk);
    chk("R3 wrong code csN", int'(spiCsN), 1);

    wr(5'h02, 8'h30);
    // opcode + three receive bytes
    runTxn({8'h9F, 40'h0}, 32, 32, 64'hC2_25_18_7E_0000_0000);
    // full bank of opcode and five bytes
    runTxn(48'hA5_3C_5A_0F_F0_81, 48, 48, 64'h1234_5678_9ABC_DEF0);
    // count above limit stored as 56, zeros after bank
    runTxn(48'h06_81_42_24_18_FF, 64, 56, 64'hF0E1_D2C3_B4A5_9687);
    // single opcode byte
    runTxn(48'h05_00_00_00_00_00, 8, 8, 64'h5A00_0000_0000_0000);

    finishRun();
  end
endmodule